// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Status Flags

This block buffers 18-bit words between a producer and a consumer. Each side has its own free-running clock and its own enable. The two clocks may be one shared net or fully unrelated. Words enter on write-clock edges while the write enable is high and the buffer is not full. Each accepted read moves the oldest stored word into an output register, which sits behind an output-enable gate.

Status comes in five forms: empty, full, half-full, almost-empty and almost-full. The two "almost" flags compare the fill level with offsets held in a small threshold register. That register is loaded through a write-side configuration strobe and returns to a default value on reset. The pointers cross between the clock domains in Gray code through multi-stage synchronizers. For that reason each flag reflects the opposite side's activity only after the synchronizer delay.

A retransmit pulse rewinds the read side to the first word stored since reset, so a short burst can be replayed. Retransmit is valid only while no more than the depth has been written since reset.

Top module: `dcfifo_pflag`

## Requirements
- R1: On a write-clock edge where `wen` is 1 and `full` is 0, the word on `din` is stored as the newest entry. Entries are read back in the order they were written.
- R2: On a read-clock edge where `ren` is 1, `rt` is 0 and `empty` is 0, the oldest unread word is loaded into the output register. The output register holds its value on every other edge and is zero after reset.
- R3: `empty` is 1 when the read side's synchronized view of the write count equals the read count. A write becomes visible to `empty` after the second read-clock edge that follows it.
- R4: `full` is 1 when the write count minus the write side's synchronized view of the read count equals DEPTH (16 by default). A read becomes visible to `full` after the second write-clock edge that follows it.
- R5: A write while `full` is 1 and a read while `empty` is 1 change neither the stored data, the pointers nor the output register.
- R6: Both flags use the write-side level. `half_full` is 1 when that level exceeds DEPTH/2. `almost_full` is 1 when that level is at least DEPTH minus the full-side offset.
- R7: `almost_empty` is 1 when the read-side level (the synchronized write count minus the read count) is at most the empty-side offset.
- R8: On a write-clock edge with `cfg_we` = 1, `cfg_val` is loaded into the empty-side offset when `cfg_sel` = 0 and into the full-side offset when `cfg_sel` = 1. Reset sets both offsets to DEF_OFS (7).
- R9: On a read-clock edge with `rt` = 1, the read position returns to the first word written since reset, and `ren` is ignored on that edge. The next reads replay the stored sequence from its start.
- R10: `dout` equals the output register while `oe` is 1 and is all zeros while `oe` is 0.
- R11: While `rst_n` is 0, `empty` = 1, `almost_empty` = 1, `full` = 0, `half_full` = 0, `almost_full` = 0 and `dout` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| wen | input | 1 | Write request |
| din | input | 18 | Write data |
| cfg_we | input | 1 | Offset load strobe (write clock) |
| cfg_sel | input | 1 | Offset select: 0 empty side, 1 full side |
| cfg_val | input | 4 | Offset value |
| ren | input | 1 | Read request |
| rt | input | 1 | Retransmit (rewind read side) |
| oe | input | 1 | Output enable for `dout` |
| dout | output | 18 | Gated output register |
| empty | output | 1 | No unread word (read domain) |
| full | output | 1 | DEPTH words stored (write domain) |
| half_full | output | 1 | Level above DEPTH/2 (write domain) |
| almost_full | output | 1 | Level at or above DEPTH minus full-side offset |
| almost_empty | output | 1 | Level at or below empty-side offset |

## Verification
The clocks are tied together so that a reference model with integer counters and a data queue can predict every flag in every cycle, including the two-edge synchronizer lag. Isolated bursts separate the write path from the read path and expose that lag on `empty`. Filling past capacity and draining past empty separate the full and empty guards from the counters. Reprogrammed offsets move the almost-flag crossing points away from the default, which distinguishes a threshold compare from a hard-wired one. A reset followed by a short burst, partial reads and retransmit (with `ren` held high) shows that the rewind restarts at the first word and takes precedence over the read. Long simultaneous read and write streaming with `oe` toggled separates the output gate from the output register.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

   typedef enum logic {
      OFS_EMPTY_SIDE = 1'b0,
      OFS_FULL_SIDE  = 1'b1
   } ofs_sel_e;

   function automatic logic [31:0] bin2gray(input logic [31:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [31:0] gray2bin(input logic [31:0] g);
      logic [31:0] b;
      b[31] = g[31];
      for (int i = 30; i >= 0; i--) begin
         b[i] = b[i+1] ^ g[i];
      end
      return b;
   endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
   parameter int W      = 5,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stg
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
   parameter int DATA_W = 18,
   parameter int ADDR_W = 4
) (
   input  logic              wclk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rclk,
   input  logic              rst_n,
   input  logic              re,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] q
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] store [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) store[waddr] <= wdata;
   end

   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (re) q <= store[raddr];
   end

endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl #(
   parameter int ADDR_W  = 4,
   parameter int STAGES  = 2,
   parameter int DEF_OFS = 7
) (
   input  logic              wclk,
   input  logic              rst_n,
   input  logic              wen,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [ADDR_W-1:0] cfg_val,
   input  logic [ADDR_W:0]   rgray_in,
   output logic              wr_go,
   output logic [ADDR_W:0]   wbin,
   output logic [ADDR_W:0]   wgray,
   output logic [ADDR_W-1:0] ae_ofs,
   output logic              full,
   output logic              half_full,
   output logic              almost_full
);

   import dcf_pkg::*;

   localparam int PW    = ADDR_W + 1;
   localparam int DEPTH = 1 << ADDR_W;

   logic [PW-1:0]     rgray_s;
   logic [PW-1:0]     rbin_s;
   logic [PW-1:0]     lvl;
   logic [PW-1:0]     wbin_nx;
   logic [ADDR_W-1:0] af_ofs;

   dcf_sync #(.W(PW), .STAGES(STAGES)) u_rsync (
      .clk   (wclk),
      .rst_n (rst_n),
      .d     (rgray_in),
      .q     (rgray_s)
   );

   assign rbin_s  = PW'(gray2bin(32'(rgray_s)));
   assign lvl     = wbin - rbin_s;
   assign full    = (wgray == {~rgray_s[PW-1:PW-2], rgray_s[PW-3:0]});
   assign wr_go   = wen & ~full;
   assign wbin_nx = wbin + 1'b1;

   assign half_full   = (lvl > PW'(DEPTH / 2));
   assign almost_full = (lvl >= (PW'(DEPTH) - {1'b0, af_ofs}));

   always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n) begin
         wbin  <= '0;
         wgray <= '0;
      end else if (wr_go) begin
         wbin  <= wbin_nx;
         wgray <= PW'(bin2gray(32'(wbin_nx)));
      end
   end

   always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n) begin
         ae_ofs <= ADDR_W'(DEF_OFS);
         af_ofs <= ADDR_W'(DEF_OFS);
      end else if (cfg_we) begin
         if (ofs_sel_e'(cfg_sel) == OFS_FULL_SIDE) af_ofs <= cfg_val;
         else                                      ae_ofs <= cfg_val;
      end
   end

endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl #(
   parameter int ADDR_W = 4,
   parameter int STAGES = 2
) (
   input  logic              rclk,
   input  logic              rst_n,
   input  logic              ren,
   input  logic              rt,
   input  logic [ADDR_W:0]   wgray_in,
   input  logic [ADDR_W-1:0] ae_ofs,
   output logic              rd_go,
   output logic [ADDR_W:0]   rbin,
   output logic [ADDR_W:0]   rgray,
   output logic              empty,
   output logic              almost_empty
);

   import dcf_pkg::*;

   localparam int PW = ADDR_W + 1;

   logic [PW-1:0] wgray_s;
   logic [PW-1:0] wbin_s;
   logic [PW-1:0] lvl;
   logic [PW-1:0] rbin_nx;

   dcf_sync #(.W(PW), .STAGES(STAGES)) u_wsync (
      .clk   (rclk),
      .rst_n (rst_n),
      .d     (wgray_in),
      .q     (wgray_s)
   );

   assign wbin_s       = PW'(gray2bin(32'(wgray_s)));
   assign lvl          = wbin_s - rbin;
   assign empty        = (rgray == wgray_s);
   assign almost_empty = (lvl <= {1'b0, ae_ofs});
   assign rd_go        = ren & ~rt & ~empty;
   assign rbin_nx      = rbin + 1'b1;

   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n) begin
         rbin  <= '0;
         rgray <= '0;
      end else if (rt) begin
         rbin  <= '0;
         rgray <= '0;
      end else if (rd_go) begin
         rbin  <= rbin_nx;
         rgray <= PW'(bin2gray(32'(rbin_nx)));
      end
   end

endmodule

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag #(
   parameter int DATA_W      = 18,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2,
   parameter int DEF_OFS     = 7
) (
   input  logic              wclk,
   input  logic              rclk,
   input  logic              rst_n,
   input  logic              wen,
   input  logic [DATA_W-1:0] din,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [ADDR_W-1:0] cfg_val,
   input  logic              ren,
   input  logic              rt,
   input  logic              oe,
   output logic [DATA_W-1:0] dout,
   output logic              empty,
   output logic              full,
   output logic              half_full,
   output logic              almost_full,
   output logic              almost_empty
);

   localparam int PW    = ADDR_W + 1;
   localparam int DEPTH = 1 << ADDR_W;

   if (DATA_W < 1) begin : g_bad_dw
      $error("dcfifo_pflag: DATA_W must be at least 1");
   end
   if (ADDR_W < 2 || ADDR_W > 12) begin : g_bad_aw
      $error("dcfifo_pflag: ADDR_W must lie in 2..12");
   end
   if (SYNC_STAGES < 2) begin : g_bad_ss
      $error("dcfifo_pflag: SYNC_STAGES must be at least 2");
   end
   if (DEF_OFS < 0 || DEF_OFS >= DEPTH) begin : g_bad_ofs
      $error("dcfifo_pflag: DEF_OFS must lie below DEPTH");
   end

   logic              wr_go;
   logic              rd_go;
   logic [PW-1:0]     wptr;
   logic [PW-1:0]     wgray;
   logic [PW-1:0]     rptr;
   logic [PW-1:0]     rgray;
   logic [ADDR_W-1:0] ae_ofs;
   logic [DATA_W-1:0] q_reg;

   dcf_wr_ctl #(
      .ADDR_W  (ADDR_W),
      .STAGES  (SYNC_STAGES),
      .DEF_OFS (DEF_OFS)
   ) u_wr (
      .wclk        (wclk),
      .rst_n       (rst_n),
      .wen         (wen),
      .cfg_we      (cfg_we),
      .cfg_sel     (cfg_sel),
      .cfg_val     (cfg_val),
      .rgray_in    (rgray),
      .wr_go       (wr_go),
      .wbin        (wptr),
      .wgray       (wgray),
      .ae_ofs      (ae_ofs),
      .full        (full),
      .half_full   (half_full),
      .almost_full (almost_full)
   );

   dcf_rd_ctl #(
      .ADDR_W (ADDR_W),
      .STAGES (SYNC_STAGES)
   ) u_rd (
      .rclk         (rclk),
      .rst_n        (rst_n),
      .ren          (ren),
      .rt           (rt),
      .wgray_in     (wgray),
      .ae_ofs       (ae_ofs),
      .rd_go        (rd_go),
      .rbin         (rptr),
      .rgray        (rgray),
      .empty        (empty),
      .almost_empty (almost_empty)
   );

   dcf_mem #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_mem (
      .wclk  (wclk),
      .we    (wr_go),
      .waddr (wptr[ADDR_W-1:0]),
      .wdata (din),
      .rclk  (rclk),
      .rst_n (rst_n),
      .re    (rd_go),
      .raddr (rptr[ADDR_W-1:0]),
      .q     (q_reg)
   );

   assign dout = oe ? q_reg : '0;

endmodule

// File: rtl/dcfifo_pflag_chk.sv
module dcfifo_pflag_chk #(
   parameter int ADDR_W = 4
) (
   input logic            wclk,
   input logic            rclk,
   input logic            rst_n,
   input logic            wen,
   input logic            ren,
   input logic            rt,
   input logic            full,
   input logic            empty,
   input logic            half_full,
   input logic            almost_full,
   input logic [ADDR_W:0] wptr,
   input logic [ADDR_W:0] rptr
);

   a_r1_write_advances: assert property (@(posedge wclk) disable iff (!rst_n)
      (wen && !full) |=> (wptr == $past(wptr) + 1'b1));

   a_r5_no_overflow: assert property (@(posedge wclk) disable iff (!rst_n)
      (wen && full) |=> $stable(wptr));

   a_r5_no_underflow: assert property (@(posedge rclk) disable iff (!rst_n)
      (ren && empty && !rt) |=> $stable(rptr));

   a_r6_full_implies_af: assert property (@(posedge wclk) disable iff (!rst_n)
      full |-> almost_full);

   a_r6_full_implies_hf: assert property (@(posedge wclk) disable iff (!rst_n)
      full |-> half_full);

   a_r9_rt_rewinds: assert property (@(posedge rclk) disable iff (!rst_n)
      rt |=> (rptr == '0));

endmodule

bind dcfifo_pflag dcfifo_pflag_chk #(.ADDR_W(ADDR_W)) u_chk (
   .wclk        (wclk),
   .rclk        (rclk),
   .rst_n       (rst_n),
   .wen         (wen),
   .ren         (ren),
   .rt          (rt),
   .full        (full),
   .empty       (empty),
   .half_full   (half_full),
   .almost_full (almost_full),
   .wptr        (wptr),
   .rptr        (rptr)
);

// File: tb/dcfifo_pflag_bench.sv
`timescale 1ns/100ps
module dcfifo_pflag_bench;

   localparam int DW    = 18;
   localparam int AW    = 4;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wen = 1'b0, ren = 1'b0, rt = 1'b0, oe = 1'b1;
   logic          cfg_we = 1'b0, cfg_sel = 1'b0;
   logic [AW-1:0] cfg_val = '0;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dout;
   logic          empty, full, half_full, almost_full, almost_empty;

   int    n_chk = 0, n_fail = 0;
   string phase = "R11";
   bit    done = 1'b0;

   // reference model state
   int          wr_n, rd_n, wr_s1, wr_s2, rd_s1, rd_s2, ae_o, af_o;
   logic [DW-1:0] hist [$];
   logic [DW-1:0] q_m;
   bit          dw, dr;

   always #2 clk = ~clk;

   dcfifo_pflag u_dcfifo_pflag (
      .wclk (clk), .rclk (clk), .rst_n (rst_n),
      .wen (wen), .din (din),
      .cfg_we (cfg_we), .cfg_sel (cfg_sel), .cfg_val (cfg_val),
      .ren (ren), .rt (rt), .oe (oe),
      .dout (dout), .empty (empty), .full (full), .half_full (half_full),
      .almost_full (almost_full), .almost_empty (almost_empty)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_n = 0; rd_n = 0; wr_s1 = 0; wr_s2 = 0; rd_s1 = 0; rd_s2 = 0;
         ae_o = 7; af_o = 7; q_m = '0; hist.delete();
      end else begin
         dw = wen && !((wr_n - rd_s2) == DEPTH);
         dr = ren && !rt && (wr_s2 != rd_n);
         wr_s2 = wr_s1; wr_s1 = wr_n;
         rd_s2 = rd_s1; rd_s1 = rd_n;
         if (rt) rd_n = 0;
         else if (dr) begin q_m = hist[rd_n]; rd_n++; end
         if (dw) begin hist.push_back(din); wr_n++; end
         if (cfg_we) begin
            if (cfg_sel) af_o = int'(cfg_val);
            else         ae_o = int'(cfg_val);
         end
      end
   end

   task automatic chk(input string tag, input string nm,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s (phase %s) %s: actual %0h expected %0h",
                  tag, phase, nm, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         int lw, lr;
         lw = wr_n - rd_s2;
         lr = wr_s2 - rd_n;
         chk(rst_n ? "R3"  : "R11", "empty",        32'(empty),        32'(lr == 0));
         chk(rst_n ? "R4"  : "R11", "full",         32'(full),         32'(lw == DEPTH));
         chk(rst_n ? "R6"  : "R11", "half_full",    32'(half_full),    32'(lw > DEPTH / 2));
         chk(rst_n ? "R6"  : "R11", "almost_full",  32'(almost_full),  32'(lw >= DEPTH - af_o));
         chk(rst_n ? "R7"  : "R11", "almost_empty", 32'(almost_empty), 32'(lr <= ae_o));
         chk(rst_n ? (oe ? "R2" : "R10") : "R11", "dout",
             32'(dout), 32'(oe ? q_m : '0));
      end
   end

   task automatic cyc(input bit w, input logic [DW-1:0] d, input bit r, input bit t);
      wen = w; din = d; ren = r; rt = t;
      @(posedge clk); #1;
      wen = 0; ren = 0; rt = 0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(0, '0, 0, 0);
   endtask

   task automatic do_reset();
      rst_n = 0; phase = "R11";
      idle(3);
      rst_n = 1;
   endtask

   initial begin
      #1;
      do_reset();
      idle(1);
      phase = "R1";
      for (int i = 0; i < 5; i++) cyc(1, DW'(18'h100 + i), 0, 0);
      idle(3);
      phase = "R2";
      for (int i = 0; i < 5; i++) cyc(0, '0, 1, 0);
      phase = "R5";
      for (int i = 0; i < 3; i++) cyc(0, '0, 1, 0);
      idle(2);
      phase = "R4";
      for (int i = 0; i < 20; i++) cyc(1, DW'(18'h2A000 + i), 0, 0);
      idle(3);
      phase = "R6";
      for (int i = 0; i < 19; i++) cyc(0, '0, 1, 0);
      idle(2);
      phase = "R8";
      cfg_we = 1; cfg_sel = 0; cfg_val = 4'd2; idle(1);
      cfg_sel = 1; cfg_val = 4'd3; idle(1);
      cfg_we = 0;
      for (int i = 0; i < 14; i++) cyc(1, DW'(18'h15500 + i), 0, 0);
      idle(3);
      for (int i = 0; i < 14; i++) cyc(0, '0, 1, 0);
      idle(2);
      do_reset();
      phase = "R9";
      for (int i = 0; i < 6; i++) cyc(1, DW'(18'h30F00 + i), 0, 0);
      idle(3);
      for (int i = 0; i < 4; i++) cyc(0, '0, 1, 0);
      cyc(0, '0, 1, 1);
      idle(3);
      for (int i = 0; i < 8; i++) cyc(0, '0, 1, 0);
      cyc(0, '0, 0, 1);
      idle(3);
      cyc(0, '0, 1, 0);
      phase = "R10";
      for (int i = 0; i < 12; i++) begin
         oe = i[1];
         cyc(1, DW'(18'h0BEEF ^ (i * 37)), 1, 0);
      end
      oe = 1;
      phase = "R3";
      for (int i = 0; i < 40; i++) cyc(i % 3 != 0, DW'(i * 7919), i % 2 == 0, 0);
      idle(6);
      for (int i = 0; i < 30; i++) cyc(1, DW'(i * 131), i > 10, 0);
      idle(4);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(4 * 100000);
      if (!done) begin
         done = 1;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule